// File: doc/BRIEF.md
# Four-Level Interrupt Priority Controller

This block decides which pending interrupt a small 8-bit microcontroller core should take next. Each source owns a request flag that a hardware event sets. A flag competes only when its own enable bit and the global enable are both on. The block ranks the surviving requests by a 2-bit priority level, where 3 is the most urgent. When levels are equal, a fixed source order picks the winner. Four "level in service" flags record which levels are running or have been preempted. A new request is offered to the core only when its level is strictly above every level already in service.

The core answers a raised `irq_o` by asserting `take_i`. One cycle later the block gives a single-cycle acknowledge, a push-PC request and the service-routine address. It also marks the granted level as in service. For the two external-event sources and the two timer-overflow sources (indices 0 to 3), it clears the granted flag. Only the program counter is to be saved by the core; the status word is left to software. Any other source keeps its flag until software clears it. A return-from-interrupt strobe ends service of the highest level currently marked.

Top module: `intc_prio4`

## Requirements
- R1: Flags. After reset all flags are 0. A `req_set_i` bit sets its flag at the next clock edge. When a set and a clear reach the same bit in the same cycle, the set wins.
- R2: Source `i` can raise `irq_o` only while `flags_o[i]`, `src_en_i[i]` and `glob_en_i` are all 1. With `glob_en_i` at 0, `irq_o` stays 0.
- R3: The level of source `i` is `prio_i[2i+1:2i]`, with 3 the highest. The winner is a qualified source of the highest level.
- R4: Among qualified sources of equal level, the lowest index wins. Index 0 is the first external event, 1 is timer 0, 2 is the second external event, 3 is timer 1, and 4 and up are the other sources.
- R5: When no level is in service, a winner of any level raises `irq_o`. Otherwise the winner must be strictly above the highest in-service level; a winner of equal or lower level keeps `irq_o` low.
- R6: If `take_i` and `irq_o` are both 1 in a cycle, then in the next cycle `ack_o` and `push_pc_o` are 1 for exactly one cycle. In that cycle, `lvl_o` holds the granted level and `vector_o` equals 0x0003 + 8 × winner index.
- R7: Accepting a request sets `active_o[level]` for the granted level. After reset, `active_o` is 0.
- R8: On acceptance, the winner's flag is cleared if its index is 0 to 3. Flags of sources with index 4 and up stay set.
- R9: A `flag_clr_i` bit clears its flag at the next clock edge. This is how software ends a request that is not cleared on acceptance.
- R10: A `reti_i` strobe clears the highest set bit of `active_o` at the next edge. Lower in-service levels are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_set_i | input | N_SRC | Hardware set strobes, one per source flag |
| flag_clr_i | input | N_SRC | Software clear strobes, one per source flag |
| glob_en_i | input | 1 | Global interrupt enable |
| src_en_i | input | N_SRC | Per-source enables |
| prio_i | input | 2*N_SRC | 2-bit level per source, source i at bits 2i+1:2i |
| take_i | input | 1 | Core accepts the offered request |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | A request is offered to the core |
| ack_o | output | 1 | One-cycle acknowledge |
| push_pc_o | output | 1 | Request to push the program counter |
| vector_o | output | 16 | Service-routine address |
| lvl_o | output | 2 | Level of the accepted request |
| active_o | output | 4 | Level-in-service flags, bit n for level n |
| flags_o | output | N_SRC | Request flags |

## Verification
`irq_o` is combinational on the registered flags and in-service bits. Flags and in-service bits change one edge after a strobe. `ack_o`, `push_pc_o`, `vector_o` and `lvl_o` appear in the cycle after the `take_i` cycle. The bench drives inputs and samples outputs on falling edges. So each flag or in-service result is read one falling edge after its strobe, and `irq_o` is read in that same window. The acknowledge group is read on the falling edge that follows the take, and read again one edge later to confirm the pulse has ended.

// File: rtl/intc_prio4_pkg.sv
package intc_prio4_pkg;
  localparam int LVL_W = 2;
  localparam int N_LVL = 4;
  localparam int VEC_W = 16;

  // highest set level in the in-service mask (0 if none)
  function automatic logic [LVL_W-1:0] top_level(input logic [N_LVL-1:0] act);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 0; i < N_LVL; i++)
      if (act[i]) r = LVL_W'(i);
    return r;
  endfunction

  // mask with the highest set bit removed
  function automatic logic [N_LVL-1:0] drop_top(input logic [N_LVL-1:0] act);
    logic [N_LVL-1:0] r;
    logic             done;
    r    = act;
    done = 1'b0;
    for (int i = N_LVL - 1; i >= 0; i--)
      if (act[i] && !done) begin
        r[i] = 1'b0;
        done = 1'b1;
      end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] vec_addr(input int base, input int step, input int idx);
    return VEC_W'(base + step * idx);
  endfunction
endpackage

// File: rtl/intc_prio4_flags.sv
module intc_prio4_flags #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] sw_clr_i,
  input  logic [N_SRC-1:0] hw_clr_i,
  output logic [N_SRC-1:0] flags_o
);
  logic [N_SRC-1:0] flags_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flags_q[i] <= 1'b0;
      else if (set_i[i])     flags_q[i] <= 1'b1;
      else if (sw_clr_i[i] || hw_clr_i[i]) flags_q[i] <= 1'b0;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/intc_prio4_arb.sv
module intc_prio4_arb
  import intc_prio4_pkg::*;
#(
  parameter int N_SRC = 6,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]       cand_i,
  input  logic [2*N_SRC-1:0]     prio_i,
  output logic                   found_o,
  output logic [LVL_W-1:0]       lvl_o,
  output logic [IDX_W-1:0]       idx_o
);
  always_comb begin
    found_o = 1'b0;
    lvl_o   = '0;
    idx_o   = '0;
    // ascending scan with strict compare keeps the lowest index on ties
    for (int i = 0; i < N_SRC; i++) begin
      if (cand_i[i] && (!found_o || prio_i[2*i +: LVL_W] > lvl_o)) begin
        found_o = 1'b1;
        lvl_o   = prio_i[2*i +: LVL_W];
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_prio4_levels.sv
module intc_prio4_levels
  import intc_prio4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_i,
  input  logic [LVL_W-1:0] grant_lvl_i,
  input  logic             reti_i,
  output logic [N_LVL-1:0] active_o
);
  logic [N_LVL-1:0] act_q;
  logic [N_LVL-1:0] after_reti;
  logic [N_LVL-1:0] set_mask;

  always_comb begin
    after_reti = reti_i ? drop_top(act_q) : act_q;
    set_mask   = '0;
    if (grant_i) set_mask[grant_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= after_reti | set_mask;
  end

  assign active_o = act_q;
endmodule

// File: rtl/intc_prio4.sv
module intc_prio4
  import intc_prio4_pkg::*;
#(
  parameter int N_SRC      = 6,
  parameter int AUTO_CLR_N = 4,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STEP   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     req_set_i,
  input  logic [N_SRC-1:0]     flag_clr_i,
  input  logic                 glob_en_i,
  input  logic [N_SRC-1:0]     src_en_i,
  input  logic [2*N_SRC-1:0]   prio_i,
  input  logic                 take_i,
  input  logic                 reti_i,
  output logic                 irq_o,
  output logic                 ack_o,
  output logic                 push_pc_o,
  output logic [VEC_W-1:0]     vector_o,
  output logic [LVL_W-1:0]     lvl_o,
  output logic [N_LVL-1:0]     active_o,
  output logic [N_SRC-1:0]     flags_o
);
  localparam int IDX_W = $clog2(N_SRC);

  // named internal events for the checker
  logic [N_SRC-1:0] cand;
  logic             found;
  logic [LVL_W-1:0] win_lvl;
  logic [IDX_W-1:0] win_idx;
  logic             preempt_ok;
  logic             grant;
  logic [N_SRC-1:0] auto_clr;

  intc_prio4_flags #(.N_SRC(N_SRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (req_set_i),
    .sw_clr_i (flag_clr_i),
    .hw_clr_i (auto_clr),
    .flags_o  (flags_o)
  );

  assign cand = flags_o & src_en_i & {N_SRC{glob_en_i}};

  intc_prio4_arb #(.N_SRC(N_SRC)) u_arb (
    .cand_i  (cand),
    .prio_i  (prio_i),
    .found_o (found),
    .lvl_o   (win_lvl),
    .idx_o   (win_idx)
  );

  assign preempt_ok = (active_o == '0) || (win_lvl > top_level(active_o));
  assign irq_o      = found && preempt_ok;
  assign grant      = take_i && irq_o;

  always_comb begin
    auto_clr = '0;
    if (grant && (32'(win_idx) < AUTO_CLR_N)) auto_clr[win_idx] = 1'b1;
  end

  intc_prio4_levels u_levels (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_i     (grant),
    .grant_lvl_i (win_lvl),
    .reti_i      (reti_i),
    .active_o    (active_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_o     <= 1'b0;
      push_pc_o <= 1'b0;
      vector_o  <= '0;
      lvl_o     <= '0;
    end else begin
      ack_o     <= grant;
      push_pc_o <= grant;
      if (grant) begin
        vector_o <= vec_addr(VEC_BASE, VEC_STEP, 32'(win_idx));
        lvl_o    <= win_lvl;
      end
    end
  end
endmodule

// File: rtl/intc_prio4_chk.sv
module intc_prio4_chk
  import intc_prio4_pkg::*;
#(
  parameter int N_SRC      = 6,
  parameter int AUTO_CLR_N = 4,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] req_set_i,
  input logic             glob_en_i,
  input logic             take_i,
  input logic             reti_i,
  input logic             irq_o,
  input logic             ack_o,
  input logic [LVL_W-1:0] lvl_o,
  input logic [N_LVL-1:0] active_o,
  input logic [N_SRC-1:0] flags_o,
  input logic [IDX_W-1:0] win_idx
);
  // R2
  a_r2_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> glob_en_i);

  // R6
  a_r6_ack_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(take_i && irq_o));

  // R7
  a_r7_level_marked: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> active_o[lvl_o]);

  // R5
  a_r5_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && $past(active_o) != '0) |-> (lvl_o > top_level($past(active_o))));

  // R10
  a_r10_reti_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && active_o != '0 && !(take_i && irq_o)) |=>
      ($countones(active_o) == $countones($past(active_o)) - 1));

  // R8
  a_r8_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && irq_o && (32'(win_idx) < AUTO_CLR_N) && !req_set_i[win_idx]) |=>
      !flags_o[$past(win_idx)]);
endmodule

bind intc_prio4 intc_prio4_chk #(.N_SRC(N_SRC), .AUTO_CLR_N(AUTO_CLR_N)) u_chk (.*);

// File: tb/test_intc_prio4.sv
module test_intc_prio4;
  localparam int N = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   req_set_i = '0;
  logic [N-1:0]   flag_clr_i = '0;
  logic           glob_en_i = 1'b0;
  logic [N-1:0]   src_en_i = '0;
  logic [2*N-1:0] prio_i = '0;
  logic           take_i = 1'b0;
  logic           reti_i = 1'b0;
  logic           irq_o, ack_o, push_pc_o;
  logic [15:0]    vector_o;
  logic [1:0]     lvl_o;
  logic [3:0]     active_o;
  logic [N-1:0]   flags_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  intc_prio4 i_intc_prio4 (.*);

  typedef struct packed {
    logic [5:0]  set;
    logic [5:0]  en;
    logic [11:0] prio;
    logic        glob;
    logic        irq;
    logic [15:0] vec;
    logic [1:0]  lvl;
    logic [5:0]  flags_after;
  } vec_t;

  // vector = 0x0003 + 8*index; flags_after: indices 0..3 cleared on accept
  localparam vec_t TBL [8] = '{
    '{6'b000001, 6'b111111, 12'h000, 1'b1, 1'b1, 16'h0003, 2'd0, 6'b000000},
    '{6'b111111, 6'b111111, 12'h000, 1'b1, 1'b1, 16'h0003, 2'd0, 6'b111110},
    '{6'b111110, 6'b111111, 12'h000, 1'b1, 1'b1, 16'h000B, 2'd0, 6'b111100},
    '{6'b110000, 6'b111111, 12'hD00, 1'b1, 1'b1, 16'h002B, 2'd3, 6'b110000},
    '{6'b001010, 6'b111111, 12'h084, 1'b1, 1'b1, 16'h001B, 2'd2, 6'b000010},
    '{6'b111111, 6'b111111, 12'h000, 1'b0, 1'b0, 16'h0000, 2'd0, 6'b111111},
    '{6'b000100, 6'b111011, 12'h000, 1'b1, 1'b0, 16'h0000, 2'd0, 6'b000100},
    '{6'b010100, 6'b111111, 12'h220, 1'b1, 1'b1, 16'h0013, 2'd2, 6'b010000}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_set_i = '0; flag_clr_i = '0; take_i = 1'b0; reti_i = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic pulse_set(input logic [N-1:0] m);
    req_set_i = m; tick(); req_set_i = '0;
  endtask

  task automatic do_take();
    take_i = 1'b1; tick(); take_i = 1'b0;
  endtask

  task automatic do_reti();
    reti_i = 1'b1; tick(); reti_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // reset state R1 R7
    check(flags_o == 0, "R1", "reset flags", 32'(flags_o), 0);
    check(active_o == 0, "R7", "reset active", 32'(active_o), 0);
    check(!irq_o && !ack_o, "R6", "reset irq/ack", {irq_o, ack_o}, 0);

    // table walk: R2 R3 R4 R6 R8
    foreach (TBL[k]) begin
      do_reset();
      glob_en_i = TBL[k].glob; src_en_i = TBL[k].en; prio_i = TBL[k].prio;
      pulse_set(TBL[k].set);
      check(flags_o == TBL[k].set, "R1", $sformatf("row%0d flags set", k), 32'(flags_o), 32'(TBL[k].set));
      check(irq_o == TBL[k].irq, "R2", $sformatf("row%0d irq", k), 32'(irq_o), 32'(TBL[k].irq));
      if (TBL[k].irq) begin
        do_take();
        check(ack_o && push_pc_o, "R6", $sformatf("row%0d ack/push", k), {ack_o, push_pc_o}, 3);
        check(vector_o == TBL[k].vec, "R4", $sformatf("row%0d vector", k), 32'(vector_o), 32'(TBL[k].vec));
        check(lvl_o == TBL[k].lvl, "R3", $sformatf("row%0d level", k), 32'(lvl_o), 32'(TBL[k].lvl));
        check(active_o == 4'(1 << TBL[k].lvl), "R7", $sformatf("row%0d active", k), 32'(active_o), 1 << TBL[k].lvl);
        check(flags_o == TBL[k].flags_after, "R8", $sformatf("row%0d flags after", k), 32'(flags_o), 32'(TBL[k].flags_after));
        tick();
        check(!ack_o && !push_pc_o, "R6", $sformatf("row%0d pulse ends", k), {ack_o, push_pc_o}, 0);
      end
    end

    // preemption and return: R5 R9 R10
    do_reset();
    glob_en_i = 1'b1; src_en_i = '1; prio_i = 12'hD01; // src0=1 src4=1 src5=3
    pulse_set(6'b000001);
    do_take();
    check(vector_o == 16'h0003 && active_o == 4'b0010, "R7", "first grant", {vector_o, 12'h0, active_o}, 32'h00030002);
    pulse_set(6'b010000);
    check(!irq_o, "R5", "equal level waits", 32'(irq_o), 0);
    pulse_set(6'b100000);
    check(irq_o, "R5", "higher level offered", 32'(irq_o), 1);
    do_take();
    check(vector_o == 16'h002B && lvl_o == 2'd3, "R5", "nested grant", {vector_o, 14'h0, lvl_o}, 32'h002B0003);
    check(active_o == 4'b1010, "R7", "nested active", 32'(active_o), 32'hA);
    check(flags_o == 6'b110000, "R8", "other sources kept", 32'(flags_o), 32'h30);
    flag_clr_i = 6'b100000; tick(); flag_clr_i = '0;
    check(flags_o == 6'b010000, "R9", "software clear", 32'(flags_o), 32'h10);
    do_reti();
    check(active_o == 4'b0010, "R10", "reti drops top", 32'(active_o), 2);
    check(!irq_o, "R5", "still equal after reti", 32'(irq_o), 0);
    do_reti();
    check(active_o == 4'b0000, "R10", "reti drops last", 32'(active_o), 0);
    check(irq_o, "R5", "idle grants any level", 32'(irq_o), 1);
    do_take();
    check(vector_o == 16'h0023 && lvl_o == 2'd1, "R6", "pending source served", {vector_o, 14'h0, lvl_o}, 32'h00230001);

    // set beats clear in same cycle: R1
    req_set_i = 6'b001000; flag_clr_i = 6'b001000; tick();
    req_set_i = '0; flag_clr_i = '0;
    check(flags_o[3], "R1", "set wins over clear", 32'(flags_o[3]), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule